// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block hunts through the divider space of a phase-locked loop for the M, N and P1 setting whose output frequency lands closest to a requested pixel clock. A caller presents the wanted clock in kHz, picks one of four limit sets with a two-bit selector, optionally says that the serial digital port is fed by an external reference, and pulses `start`. The engine latches these inputs and sweeps every legal combination. M is the outer loop, N the middle loop and P1 the inner loop, each running from its minimum to its maximum. Candidates whose VCO frequency falls outside the set's window are skipped, and two shortcuts cut a loop short.

Each evaluated candidate needs two integer divisions: the achieved frequency, and the ratio of the requested clock to it scaled by ten thousand. One shared multi-cycle restoring divider performs both, so a candidate costs a bounded number of cycles. When the sweep ends, the engine pulses `done` and holds the best triple, the achieved frequency, the absolute error in parts per ten thousand and a pass flag. It also holds the register encodings of the chosen values, formed according to the port type of the selected limit set. When the search fails, all three encodings are zero.

Top module: `pll_div_search`

## Requirements
- R1: A `start` pulse is accepted only when `busy` is low. `busy` is high in the following cycle and stays high until the cycle in which `done` pulses high for exactly one cycle; `busy` is low in that cycle. A `start` pulse while `busy` is high has no effect on the result.
- R2: `limit_sel` selects the limit set: 0 = 200000 kHz reference, M 10..17, P1 2..8, VCO 2000000..3400000; 1 = 100000 kHz, M 20..34, P1 2..8, VCO 1000000..3400000; 2 = 166000 kHz, M 12..20, P1 2..7, VCO 2000000..3333333. These three are LVDS sets with N fixed at 1 and P2 = 14. Value 3 = serial port set: 96000 kHz reference, M 80..137, N 3..7, P1 1..2, P2 = 10, VCO 1400000..2800000.
- R3: The sweep order is M outermost, then N, then P1, each ascending. The best error starts at 100000 and is replaced only by a strictly smaller absolute error, so the earliest setting that reaches the minimum is reported. Once the best error is 0, the sweep ends after the current M value.
- R4: With post divider D = P1*P2 and VCO = request*D: a VCO above the window maximum ends the current P1 sweep, and a VCO below the window minimum skips that candidate.
- R5: The achieved frequency is ref*M/(N*D) and the error is 10000 - request*10000/achieved, both with integer truncation. `achieved_khz` and `err_ppt` give the achieved frequency and the absolute error of the best setting. If nothing is evaluated, they read 0 and 100000 and the triple reads 0.
- R6: When a candidate's signed error is below minus the current best error, the rest of that P1 sweep is abandoned.
- R7: `pass` is 1 when the final best error is at most the allowed error. The allowed error is 46 for the serial set without an external reference, and the requested clock value for LVDS sets.
- R8: With `ext_ref` high and the serial set selected, the reference equals the requested clock and the allowed error is 0. For LVDS sets, `ext_ref` has no effect.
- R9: Serial set encodings: `enc_p1` = 1<<(P1-1), `enc_m` = M-2, `enc_n` = 1<<(N-1).
- R10: LVDS encodings: `enc_p1` = 1<<(P1-2), `enc_n` = N. `enc_m` is entry M-10 of a 6-bit sequence that starts at 0x2B, where each next entry is {x[0]^x[5], x[5:1]} (0x2B, 0x15, 0x2A, 0x35, ...).
- R11: When `pass` is 0, `enc_m`, `enc_n` and `enc_p1` are all zero.
- R12: After reset, `busy`, `done` and `pass` are 0 and all encodings are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (accepted when idle) |
| req_khz | input | 20 | Requested pixel clock in kHz |
| limit_sel | input | 2 | Limit set selector |
| ext_ref | input | 1 | Serial port fed by an external reference |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Best error within the allowed error |
| best_m | output | 8 | Chosen M |
| best_n | output | 4 | Chosen N |
| best_p1 | output | 4 | Chosen P1 |
| achieved_khz | output | 36 | Achieved frequency of chosen setting |
| err_ppt | output | 17 | Absolute error, parts per ten thousand |
| enc_m | output | 8 | Register encoding of M |
| enc_n | output | 8 | Register encoding of N |
| enc_p1 | output | 8 | Register encoding of P1 |

## Verification
Requests go to every limit set and are placed so that different parts of the loop control decide the outcome. Some serial requests let only the larger post divider reach the VCO window. One 200000 kHz request has its P1 sweep cut short by the window maximum, while a 100000 kHz request evaluates nearly every candidate, so the overshoot exit and the strict tie rule matter. One serial request hits no candidate at all and must fail with zero encodings. An external-reference request has an exact solution that stops the sweep early. The same LVDS request repeated with `ext_ref` high and an intruding `start` during a long search shows whether those inputs leak into the result.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    localparam int REQ_W  = 20;
    localparam int DW     = 36;
    localparam int ERR_W  = 17;
    localparam int M_W    = 8;
    localparam int N_W    = 4;
    localparam int P_W    = 4;
    localparam int P2_W   = 5;
    localparam int PD_W   = P_W + P2_W;
    localparam int VCO_W  = 22;
    localparam int ENC_W  = 8;
    localparam int SCALE  = 10000;
    localparam int ERR_INIT    = 100000;
    localparam int SERIAL_TOL  = 46;
    localparam int LVDS_M_BASE = 10;

    typedef enum logic [2:0] {
        S_IDLE, S_CAND, S_ACH_WAIT, S_ERR_GO,
        S_ERR_WAIT, S_NEXT_P1, S_NEXT_N, S_FINISH
    } srch_state_t;

    typedef struct packed {
        logic [REQ_W-1:0] ref_khz;
        logic [M_W-1:0]   m_min;
        logic [M_W-1:0]   m_max;
        logic [N_W-1:0]   n_min;
        logic [N_W-1:0]   n_max;
        logic [P_W-1:0]   p1_min;
        logic [P_W-1:0]   p1_max;
        logic [P2_W-1:0]  p2;
        logic [VCO_W-1:0] vco_min;
        logic [VCO_W-1:0] vco_max;
        logic             serial;
    } lim_t;

    function automatic lim_t get_limits(input logic [1:0] sel);
        lim_t l;
        case (sel)
            2'd0:    l = '{20'd200000, 8'd10, 8'd17, 4'd1, 4'd1, 4'd2, 4'd8,
                           5'd14, 22'd2000000, 22'd3400000, 1'b0};
            2'd1:    l = '{20'd100000, 8'd20, 8'd34, 4'd1, 4'd1, 4'd2, 4'd8,
                           5'd14, 22'd1000000, 22'd3400000, 1'b0};
            2'd2:    l = '{20'd166000, 8'd12, 8'd20, 4'd1, 4'd1, 4'd2, 4'd7,
                           5'd14, 22'd2000000, 22'd3333333, 1'b0};
            default: l = '{20'd96000, 8'd80, 8'd137, 4'd3, 4'd7, 4'd1, 4'd2,
                           5'd10, 22'd1400000, 22'd2800000, 1'b1};
        endcase
        return l;
    endfunction

    // 6-bit shift sequence used as the LVDS M code; entry idx
    function automatic logic [5:0] lvds_m_code(input logic [M_W-1:0] idx);
        logic [5:0] x;
        x = 6'h2B;
        for (int i = 0; i < 32; i++) begin
            if (i < int'(idx)) x = {x[0] ^ x[5], x[5:1]};
        end
        return x;
    endfunction

endpackage

// File: rtl/pll_seq_divider.sv
module pll_seq_divider #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem_r;
    logic [W-1:0]  quo_r;
    logic [W-1:0]  a_q, b_q;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    shifted, next_rem;
    logic          fits;

    always_comb begin
        shifted  = {rem_r[W-1:0], quo_r[W-1]};
        fits     = shifted >= {1'b0, b_q};
        next_rem = fits ? (shifted - {1'b0, b_q}) : shifted;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_r <= '0;
            quo_r <= '0;
            a_q   <= '0;
            b_q   <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_r <= '0;
                quo_r <= dividend;
                a_q   <= dividend;
                b_q   <= divisor;
                cnt   <= CW'(W);
                run   <= 1'b1;
            end else if (run) begin
                rem_r <= next_rem;
                quo_r <= {quo_r[W-2:0], fits};
                cnt   <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient  = quo_r;
    assign remainder = rem_r[W-1:0];

    // R5
    div_identity_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ((2*W)'(quotient) * (2*W)'(b_q) + (2*W)'(remainder) == (2*W)'(a_q))
                 && (b_q == '0 || remainder < b_q));

endmodule

// File: rtl/pll_reg_encoder.sv
module pll_reg_encoder
    import pll_search_pkg::*;
(
    input  logic             valid,
    input  logic             serial,
    input  logic [M_W-1:0]   m,
    input  logic [N_W-1:0]   n,
    input  logic [P_W-1:0]   p1,
    output logic [ENC_W-1:0] enc_m,
    output logic [ENC_W-1:0] enc_n,
    output logic [ENC_W-1:0] enc_p1
);
    logic [M_W-1:0] m_idx;

    always_comb begin
        m_idx  = m - M_W'(LVDS_M_BASE);
        enc_m  = '0;
        enc_n  = '0;
        enc_p1 = '0;
        if (valid) begin
            if (serial) begin
                enc_m  = m - ENC_W'(2);
                enc_n  = ENC_W'(1) << (n - N_W'(1));
                enc_p1 = ENC_W'(1) << (p1 - P_W'(1));
            end else begin
                enc_m  = {2'b00, lvds_m_code(m_idx)};
                enc_n  = ENC_W'(n);
                enc_p1 = ENC_W'(1) << (p1 - P_W'(2));
            end
        end
    end

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_search_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [REQ_W-1:0] req_khz,
    input  logic [1:0]       limit_sel,
    input  logic             ext_ref,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic [M_W-1:0]   best_m,
    output logic [N_W-1:0]   best_n,
    output logic [P_W-1:0]   best_p1,
    output logic [DW-1:0]    achieved_khz,
    output logic [ERR_W-1:0] err_ppt,
    output logic [ENC_W-1:0] enc_m,
    output logic [ENC_W-1:0] enc_n,
    output logic [ENC_W-1:0] enc_p1
);
    srch_state_t      st;
    lim_t             lim_q, lim_in;
    logic [REQ_W-1:0] req_q, ref_q, allow_q;
    logic [M_W-1:0]   m_q;
    logic [N_W-1:0]   n_q;
    logic [P_W-1:0]   p1_q;
    logic [DW-1:0]    ach_q;

    logic [PD_W-1:0]  pdiv;
    logic [DW-1:0]    vco;
    logic             vco_high, vco_ok;
    logic             div_start, div_done;
    logic [DW-1:0]    div_a, div_b, div_q, div_r;
    logic             overshoot;
    logic [DW-1:0]    abs_err;

    assign lim_in = get_limits(limit_sel);
    assign busy   = (st != S_IDLE);

    always_comb begin
        pdiv      = PD_W'(p1_q) * PD_W'(lim_q.p2);
        vco       = DW'(req_q) * DW'(pdiv);
        vco_high  = vco > DW'(lim_q.vco_max);
        vco_ok    = !vco_high && (vco >= DW'(lim_q.vco_min));
        div_start = ((st == S_CAND) && vco_ok) || (st == S_ERR_GO);
        if (st == S_CAND) begin
            div_a = DW'(ref_q) * DW'(m_q);
            div_b = DW'(n_q) * DW'(pdiv);
        end else begin
            div_a = DW'(req_q) * DW'(SCALE);
            div_b = ach_q;
        end
        overshoot = div_q > (DW'(SCALE) + DW'(err_ppt));
        abs_err   = (div_q >= DW'(SCALE)) ? (div_q - DW'(SCALE))
                                          : (DW'(SCALE) - div_q);
    end

    pll_seq_divider #(.W(DW)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (div_a),
        .divisor  (div_b),
        .done     (div_done),
        .quotient (div_q),
        .remainder(div_r)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= S_IDLE;
            lim_q        <= get_limits(2'd0);
            req_q        <= '0;
            ref_q        <= '0;
            allow_q      <= '0;
            m_q          <= '0;
            n_q          <= '0;
            p1_q         <= '0;
            ach_q        <= '0;
            done         <= 1'b0;
            pass         <= 1'b0;
            best_m       <= '0;
            best_n       <= '0;
            best_p1      <= '0;
            achieved_khz <= '0;
            err_ppt      <= ERR_W'(ERR_INIT);
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    lim_q        <= lim_in;
                    req_q        <= req_khz;
                    ref_q        <= (lim_in.serial && ext_ref) ? req_khz : lim_in.ref_khz;
                    allow_q      <= !lim_in.serial ? req_khz :
                                    (ext_ref ? '0 : REQ_W'(SERIAL_TOL));
                    m_q          <= lim_in.m_min;
                    n_q          <= lim_in.n_min;
                    p1_q         <= lim_in.p1_min;
                    pass         <= 1'b0;
                    best_m       <= '0;
                    best_n       <= '0;
                    best_p1      <= '0;
                    achieved_khz <= '0;
                    err_ppt      <= ERR_W'(ERR_INIT);
                    st           <= S_CAND;
                end
                S_CAND: begin
                    if (vco_high)    st <= S_NEXT_N;
                    else if (vco_ok) st <= S_ACH_WAIT;
                    else             st <= S_NEXT_P1;
                end
                S_ACH_WAIT: if (div_done) begin
                    ach_q <= div_q;
                    st    <= S_ERR_GO;
                end
                S_ERR_GO: st <= S_ERR_WAIT;
                S_ERR_WAIT: if (div_done) begin
                    if (overshoot) begin
                        st <= S_NEXT_N;
                    end else begin
                        if (abs_err < DW'(err_ppt)) begin
                            err_ppt      <= ERR_W'(abs_err);
                            best_m       <= m_q;
                            best_n       <= n_q;
                            best_p1      <= p1_q;
                            achieved_khz <= ach_q;
                        end
                        st <= S_NEXT_P1;
                    end
                end
                S_NEXT_P1: begin
                    if (p1_q < lim_q.p1_max) begin
                        p1_q <= p1_q + 1'b1;
                        st   <= S_CAND;
                    end else begin
                        st <= S_NEXT_N;
                    end
                end
                S_NEXT_N: begin
                    p1_q <= lim_q.p1_min;
                    if (n_q < lim_q.n_max) begin
                        n_q <= n_q + 1'b1;
                        st  <= S_CAND;
                    end else if (err_ppt == '0 || m_q >= lim_q.m_max) begin
                        st <= S_FINISH;
                    end else begin
                        m_q <= m_q + 1'b1;
                        n_q <= lim_q.n_min;
                        st  <= S_CAND;
                    end
                end
                S_FINISH: begin
                    pass <= REQ_W'(err_ppt) <= allow_q;
                    done <= 1'b1;
                    st   <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    pll_reg_encoder u_enc (
        .valid  (pass),
        .serial (lim_q.serial),
        .m      (best_m),
        .n      (best_n),
        .p1     (best_p1),
        .enc_m  (enc_m),
        .enc_n  (enc_n),
        .enc_p1 (enc_p1)
    );

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    // R2
    index_range_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_CAND) |-> (m_q >= lim_q.m_min && m_q <= lim_q.m_max &&
                            n_q >= lim_q.n_min && n_q <= lim_q.n_max &&
                            p1_q >= lim_q.p1_min && p1_q <= lim_q.p1_max));

    // R4
    vco_window_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_ERR_WAIT) |-> (vco >= DW'(lim_q.vco_min) && vco <= DW'(lim_q.vco_max)));

    // R3
    best_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (err_ppt <= $past(err_ppt)));

endmodule

// File: tb/pll_div_search_bench.sv
module pll_div_search_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [19:0] req_khz = '0;
    logic [1:0]  limit_sel = '0;
    logic        ext_ref = 1'b0;
    logic        busy, done, pass;
    logic [7:0]  best_m;
    logic [3:0]  best_n, best_p1;
    logic [35:0] achieved_khz;
    logic [16:0] err_ppt;
    logic [7:0]  enc_m, enc_n, enc_p1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pll_div_search u_pll_div_search (
        .clk(clk), .rst(rst), .start(start), .req_khz(req_khz),
        .limit_sel(limit_sel), .ext_ref(ext_ref), .busy(busy), .done(done),
        .pass(pass), .best_m(best_m), .best_n(best_n), .best_p1(best_p1),
        .achieved_khz(achieved_khz), .err_ppt(err_ppt),
        .enc_m(enc_m), .enc_n(enc_n), .enc_p1(enc_p1)
    );

    longint lim_ref[4]  = '{200000, 100000, 166000, 96000};
    longint lim_mlo[4]  = '{10, 20, 12, 80};
    longint lim_mhi[4]  = '{17, 34, 20, 137};
    longint lim_nlo[4]  = '{1, 1, 1, 3};
    longint lim_nhi[4]  = '{1, 1, 1, 7};
    longint lim_plo[4]  = '{2, 2, 2, 1};
    longint lim_phi[4]  = '{8, 8, 7, 2};
    longint lim_p2[4]   = '{14, 14, 14, 10};
    longint lim_vlo[4]  = '{2000000, 1000000, 2000000, 1400000};
    longint lim_vhi[4]  = '{3400000, 3400000, 3333333, 2800000};
    longint mcode[26]   = '{'h2B, 'h15, 'h2A, 'h35, 'h1A, 'h0D, 'h26, 'h33, 'h19,
                            'h2C, 'h36, 'h3B, 'h1D, 'h2E, 'h37, 'h1B, 'h2D, 'h16,
                            'h0B, 'h25, 'h12, 'h09, 'h24, 'h32, 'h39, 'h1C};

    task automatic check(input longint act, input longint exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=%0d expected<=190000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic run_case(input int sel, input longint req, input bit ext,
                            input bit intrude, input string p1_tag, input string pass_tag);
        longint rf, allowed, best, bm, bn, bp, bach, pd, vco, ach, q, err, a;
        longint em, en, ep;
        bit ok, seen, held;
        int waited;
        // behavioural reference sweep
        bit ser = (sel == 3);
        rf = (ser && ext) ? req : lim_ref[sel];
        allowed = !ser ? req : (ext ? 0 : 46);
        best = 100000; bm = 0; bn = 0; bp = 0; bach = 0;
        for (longint m = lim_mlo[sel]; m <= lim_mhi[sel]; m++) begin
            for (longint n = lim_nlo[sel]; n <= lim_nhi[sel]; n++) begin
                for (longint p = lim_plo[sel]; p <= lim_phi[sel]; p++) begin
                    pd = p * lim_p2[sel];
                    vco = req * pd;
                    if (vco > lim_vhi[sel]) break;
                    if (vco >= lim_vlo[sel]) begin
                        ach = (rf * m) / (n * pd);
                        q = (ach == 0) ? 64'd68719476735 : (req * 10000) / ach;
                        err = 10000 - q;
                        if (err < -best) break;
                        a = (err < 0) ? -err : err;
                        if (a < best) begin
                            best = a; bm = m; bn = n; bp = p; bach = ach;
                        end
                    end
                end
            end
            if (best == 0) break;
        end
        ok = (best <= allowed);
        if (!ok) begin em = 0; en = 0; ep = 0; end
        else if (ser) begin em = bm - 2; en = 1 << (bn - 1); ep = 1 << (bp - 1); end
        else begin em = mcode[bm - 10]; en = bn; ep = 1 << (bp - 2); end

        @(negedge clk);
        req_khz = req[19:0]; limit_sel = sel[1:0]; ext_ref = ext; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, 1, "R1", "busy after start");
        if (intrude) begin
            req_khz = 20'd54321; limit_sel = 2'd1; ext_ref = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        seen = 0; held = 1; waited = 0;
        while (!seen && waited < 100000) begin
            if (done) seen = 1;
            else begin
                if (!busy) held = 0;
                @(negedge clk);
                waited++;
            end
        end
        check(seen, 1, "R1", "done seen");
        check(held, 1, "R1", "busy held until done");
        check(busy, 0, "R1", "busy low with done");
        check(pass, ok, pass_tag, "pass");
        check(best_m, bm, "R3", "best M");
        check(best_n, bn, "R2", "best N");
        check(best_p1, bp, p1_tag, "best P1");
        check(achieved_khz, bach, "R5", "achieved");
        check(err_ppt, best, "R5", "error");
        if (!ok) begin
            check(enc_m, em, "R11", "enc M");
            check(enc_n, en, "R11", "enc N");
            check(enc_p1, ep, "R11", "enc P1");
        end else if (ser) begin
            check(enc_m, em, "R9", "enc M");
            check(enc_n, en, "R9", "enc N");
            check(enc_p1, ep, "R9", "enc P1");
        end else begin
            check(enc_m, em, "R10", "enc M");
            check(enc_n, en, "R10", "enc N");
            check(enc_p1, ep, "R10", "enc P1");
        end
        @(negedge clk);
        check(done, 0, "R1", "done one cycle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy, 0, "R12", "reset busy");
        check(done, 0, "R12", "reset done");
        check(pass, 0, "R12", "reset pass");
        check({enc_m, enc_n, enc_p1}, 0, "R12", "reset encodings");

        run_case(3, 100000, 0, 1, "R4", "R7");   // only P1=2 in window; intruding start
        run_case(3, 65000, 0, 0, "R4", "R7");    // nothing in window: fails
        run_case(3, 135000, 0, 0, "R4", "R7");
        run_case(3, 74250, 1, 0, "R3", "R8");    // exact hit, early stop
        run_case(0, 65000, 0, 0, "R4", "R7");    // VCO maximum cuts P1 sweep
        run_case(0, 65000, 1, 0, "R4", "R8");    // ext_ref ignored on LVDS
        run_case(1, 25175, 0, 0, "R6", "R7");    // many candidates, overshoot exits
        run_case(2, 108000, 0, 0, "R4", "R7");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule